// File: doc/BRIEF.md
# External Memory Bus Cycle Engine

This block turns internal read and write requests into external memory bus cycles. A requester offers a 24-bit internal address, a 16-bit write word and a direction flag with `req_valid`. When the engine is idle it takes the request and runs one external cycle through fixed phases: address (latch strobe high), strobe-low setup, data, and completion. At completion it returns a single-clock `req_ready` pulse. On reads it also returns the captured word on `rsp_rdata`.

The external side has 20 address lines, a shared 16-bit address/data bus and an active-high address latch strobe. The shared bus is split into separate in, out and per-byte output-enable ports, so the pad ring can build the tristate pins. Two static configuration inputs select a 16-bit or 8-bit bus, and multiplexed or demultiplexed operation. Each of the four combinations gives the shared pins a different address-then-data role. Only the low 20 address bits leave the block, which gives a 1-Mbyte external space.

Phase lengths are set by the parameters `ADDR_CYC`, `SETUP_CYC` and `DATA_CYC`. In the requirements, "cycle k" counts clocks after the edge at which the request was taken, starting at k = 0. A is `ADDR_CYC`, S is `SETUP_CYC`, D is `DATA_CYC`, and T = A+S+D.

Top module: `ext_bus_engine`

## Requirements
- R1: After reset, `ale`, `ad_oe_hi`, `ad_oe_lo` and `req_ready` are 0, and `ext_addr`, `ad_out` and `rsp_rdata` are all zeros.
- R2: From cycle 0 until the next accepted request, `ext_addr` equals bits 19:0 of the accepted address. Bits 23:20 have no effect on any pin.
- R3: `ale` is 1 in cycles 0 to A-1 and 0 in every other cycle, so it falls before the data phase and before completion.
- R4: `req_ready` is 1 for exactly one clock, in cycle T, and 0 otherwise.
- R5: 16-bit multiplexed (`cfg_bus16`=1, `cfg_demux`=0): in cycles 0 to A+S-1, both byte lanes drive address bits 15:0. In the data phase they drive the write word on writes and are released on reads.
- R6: 8-bit multiplexed (`cfg_bus16`=0, `cfg_demux`=0): the high lane drives address bits 15:8 in cycles 0 to T-1. The low lane drives address bits 7:0 in cycles 0 to A+S-1, then drives write bits 7:0 on writes or is released on reads.
- R7: 16-bit demultiplexed (`cfg_bus16`=1, `cfg_demux`=1): in cycles 0 to T-1, both lanes drive the write word on writes and are released on reads. They never carry address.
- R8: 8-bit demultiplexed (`cfg_bus16`=0, `cfg_demux`=1): in cycles 0 to T-1, the high lane drives bits 15:8 of the word on the internal write-data bus, for reads and writes alike. The low lane drives write bits 7:0 on writes and is released on reads.
- R9: On a read, the low lane is released (`ad_oe_lo`=0) for the whole data phase. In multiplexed modes it is still driven with address until cycle A+S-1.
- R10: On a read, `rsp_rdata` takes `ad_in` as sampled at the edge ending cycle T-1. That is all 16 bits on a 16-bit bus, or {8'h00, `ad_in[7:0]`} on an 8-bit bus. Writes leave `rsp_rdata` unchanged.
- R11: A `req_valid` raised while a cycle is running is ignored: the address does not change and no second cycle follows without a new request taken in idle.
- R12: When idle and at completion (cycle T), `ale`, `ad_oe_hi` and `ad_oe_lo` are 0, and `ad_out` is all zeros. Each lane of `ad_out` is zero whenever its enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cfg_demux | input | 1 | 1 = demultiplexed, 0 = multiplexed |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Internal address |
| req_wdata | input | 16 | Write word / internal data bus |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| ext_addr | output | 20 | External address lines |
| ad_out | output | 16 | Shared bus output value |
| ad_oe_hi | output | 1 | Output enable for shared bits 15:8 |
| ad_oe_lo | output | 1 | Output enable for shared bits 7:0 |
| ad_in | input | 16 | Shared bus input value |
| ale | output | 1 | Address latch strobe, active high |

## Verification
The bound checker checks the following on every clock:
- the strobe and the output enables stay quiet in idle;
- the strobe rises only out of an accepted request and never coincides with completion;
- completion follows the last data clock and lasts one clock;
- the address lines move only on acceptance;
- the low lane is released during read data phases;
- the read word changes only at a read capture.

The per-mode pin roles, the exact cycle counts and the captured values can only be shown by the bench. It sweeps all four width/mode combinations in both directions over several address and data patterns, compares every pin in every cycle with values it computes itself, and injects requests while a cycle is running.

// File: rtl/ebi_pkg.sv
`timescale 1ns/1ps
package ebi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_DATA  = 3'd3,
    PH_DONE  = 3'd4
  } ebi_phase_e;

  // phases in which the shared pins may carry address or data
  function automatic logic ebi_in_cycle(input ebi_phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_SETUP) || (ph == PH_DATA);
  endfunction

  // phases in which a multiplexed bus still shows address
  function automatic logic ebi_addr_window(input ebi_phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_SETUP);
  endfunction

  function automatic int ebi_max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/ebi_sequencer.sv
`timescale 1ns/1ps
module ebi_sequencer
  import ebi_pkg::*;
#(
  parameter int ADDR_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int DATA_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output ebi_phase_e phase,
  output logic       accept,
  output logic       data_last,
  output logic       idle
);

  localparam int LONGEST = ebi_max3(ADDR_CYC, SETUP_CYC, DATA_CYC);
  localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_CYC - 1);

  ebi_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             ph_end;

  always_comb begin
    case (ph_q)
      PH_ADDR:  limit = A_LAST;
      PH_SETUP: limit = S_LAST;
      PH_DATA:  limit = D_LAST;
      default:  limit = '0;
    endcase
  end

  assign ph_end    = (cnt_q == limit);
  assign idle      = (ph_q == PH_IDLE);
  assign accept    = idle && req_valid;
  assign data_last = (ph_q == PH_DATA) && ph_end;
  assign phase     = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (req_valid) ph_q <= PH_ADDR;
        end
        PH_ADDR: begin
          if (ph_end) begin
            ph_q  <= PH_SETUP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SETUP: begin
          if (ph_end) begin
            ph_q  <= PH_DATA;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (ph_end) begin
            ph_q  <= PH_DONE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ebi_request_regs.sv
`timescale 1ns/1ps
module ebi_request_regs #(
  parameter int ADDR_W = 24,
  parameter int EXT_AW = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wr_q,
  output logic [EXT_AW-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr[EXT_AW-1:0];
      wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/ebi_pin_mux.sv
`timescale 1ns/1ps
module ebi_pin_mux
  import ebi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ebi_phase_e        phase,
  input  logic              cfg_bus16,
  input  logic              cfg_demux,
  input  logic              wr,
  input  logic [DATA_W-1:0] addr_lo16,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              oe_hi,
  output logic              oe_lo,
  output logic              ale
);

  localparam int LANE_W = DATA_W / 2;

  logic              act;
  logic              awin;
  logic [LANE_W-1:0] hi_val, lo_val;

  assign act  = ebi_in_cycle(phase);
  assign awin = ebi_addr_window(phase);
  assign ale  = (phase == PH_ADDR);

  always_comb begin
    oe_hi  = 1'b0;
    oe_lo  = 1'b0;
    hi_val = '0;
    lo_val = '0;
    if (act) begin
      if (!cfg_demux) begin
        if (cfg_bus16) begin
          if (awin) begin
            oe_hi  = 1'b1;
            oe_lo  = 1'b1;
            hi_val = addr_lo16[DATA_W-1:LANE_W];
            lo_val = addr_lo16[LANE_W-1:0];
          end else if (wr) begin
            oe_hi  = 1'b1;
            oe_lo  = 1'b1;
            hi_val = wdata[DATA_W-1:LANE_W];
            lo_val = wdata[LANE_W-1:0];
          end
        end else begin
          oe_hi  = 1'b1;
          hi_val = addr_lo16[DATA_W-1:LANE_W];
          if (awin) begin
            oe_lo  = 1'b1;
            lo_val = addr_lo16[LANE_W-1:0];
          end else if (wr) begin
            oe_lo  = 1'b1;
            lo_val = wdata[LANE_W-1:0];
          end
        end
      end else begin
        if (cfg_bus16) begin
          if (wr) begin
            oe_hi  = 1'b1;
            oe_lo  = 1'b1;
            hi_val = wdata[DATA_W-1:LANE_W];
            lo_val = wdata[LANE_W-1:0];
          end
        end else begin
          oe_hi  = 1'b1;
          hi_val = wdata[DATA_W-1:LANE_W];
          if (wr) begin
            oe_lo  = 1'b1;
            lo_val = wdata[LANE_W-1:0];
          end
        end
      end
    end
  end

  assign ad_out = {hi_val, lo_val};

endmodule

// File: rtl/ebi_read_capture.sv
`timescale 1ns/1ps
module ebi_read_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              cfg_bus16,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] assemble(input logic wide,
                                                 input logic [DATA_W-1:0] din);
    logic [DATA_W-1:0] w;
    w = din;
    if (!wide) w[DATA_W-1:LANE_W] = '0;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= assemble(cfg_bus16, ad_in);
  end

endmodule

// File: rtl/ext_bus_engine.sv
`timescale 1ns/1ps
module ext_bus_engine
  import ebi_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int EXT_AW    = 20,
  parameter int DATA_W    = 16,
  parameter int ADDR_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int DATA_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bus16,
  input  logic              cfg_demux,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe_hi,
  output logic              ad_oe_lo,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale
);

  ebi_phase_e        phase;
  logic              cyc_accept;
  logic              cyc_data_last;
  logic              cyc_idle;
  logic              cyc_read_data;
  logic              rd_capture;
  logic              wr_q;
  logic [EXT_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  ebi_sequencer #(
    .ADDR_CYC (ADDR_CYC),
    .SETUP_CYC(SETUP_CYC),
    .DATA_CYC (DATA_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .phase    (phase),
    .accept   (cyc_accept),
    .data_last(cyc_data_last),
    .idle     (cyc_idle)
  );

  ebi_request_regs #(
    .ADDR_W(ADDR_W),
    .EXT_AW(EXT_AW),
    .DATA_W(DATA_W)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (cyc_accept),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .wr_q     (wr_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q)
  );

  ebi_pin_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .phase    (phase),
    .cfg_bus16(cfg_bus16),
    .cfg_demux(cfg_demux),
    .wr       (wr_q),
    .addr_lo16(addr_q[DATA_W-1:0]),
    .wdata    (wdata_q),
    .ad_out   (ad_out),
    .oe_hi    (ad_oe_hi),
    .oe_lo    (ad_oe_lo),
    .ale      (ale)
  );

  assign rd_capture    = cyc_data_last && !wr_q;
  assign cyc_read_data = (phase == PH_DATA) && !wr_q;

  ebi_read_capture #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (rd_capture),
    .cfg_bus16(cfg_bus16),
    .ad_in    (ad_in),
    .rdata    (rsp_rdata)
  );

  assign ext_addr  = addr_q;
  assign req_ready = (phase == PH_DONE);

endmodule

// File: rtl/ebi_checker.sv
`timescale 1ns/1ps
module ebi_checker #(
  parameter int EXT_AW = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              req_ready,
  input logic              ad_oe_hi,
  input logic              ad_oe_lo,
  input logic [EXT_AW-1:0] ext_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              cyc_idle,
  input logic              cyc_accept,
  input logic              cyc_data_last,
  input logic              cyc_read_data,
  input logic              rd_capture
);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_idle |-> (!ale && !ad_oe_hi && !ad_oe_lo));

  a_r3_ale_not_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !req_ready);

  a_r3_ale_rise_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(cyc_accept));

  a_r4_ready_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_data_last |=> req_ready);

  a_r4_ready_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_accept |=> $stable(ext_addr));

  a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_read_data |-> !ad_oe_lo);

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rsp_rdata));

endmodule

bind ext_bus_engine ebi_checker #(
  .EXT_AW(EXT_AW),
  .DATA_W(DATA_W)
) u_ebi_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ale          (ale),
  .req_ready    (req_ready),
  .ad_oe_hi     (ad_oe_hi),
  .ad_oe_lo     (ad_oe_lo),
  .ext_addr     (ext_addr),
  .rsp_rdata    (rsp_rdata),
  .cyc_idle     (cyc_idle),
  .cyc_accept   (cyc_accept),
  .cyc_data_last(cyc_data_last),
  .cyc_read_data(cyc_read_data),
  .rd_capture   (rd_capture)
);

// File: tb/tb_ext_bus_engine.sv
`timescale 1ns/1ps
module tb_ext_bus_engine;

  localparam int A = 2;
  localparam int S = 1;
  localparam int D = 2;
  localparam int T = A + S + D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bus16 = 1'b0, cfg_demux = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [19:0] ext_addr;
  logic [15:0] ad_out;
  logic        ad_oe_hi, ad_oe_lo;
  logic [15:0] ad_in = '0;
  logic        ale;

  int errors = 0;
  int checks = 0;
  logic [15:0] last_rd = '0;

  always #2 clk = ~clk;

  ext_bus_engine #(.ADDR_CYC(A), .SETUP_CYC(S), .DATA_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_demux(cfg_demux),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .ext_addr(ext_addr), .ad_out(ad_out), .ad_oe_hi(ad_oe_hi),
    .ad_oe_lo(ad_oe_lo), .ad_in(ad_in), .ale(ale)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_check(input logic [19:0] a_exp, input string req);
    @(negedge clk);
    chk("R12", "idle pins", {13'd0, ale, ad_oe_hi, ad_oe_lo, ad_out},
        32'd0);
    chk(req, "addr held in idle", {12'd0, ext_addr}, {12'd0, a_exp});
    chk("R4", "ready idle", {31'd0, req_ready}, 32'd0);
  endtask

  task automatic run_txn(input bit b16, input bit dm, input bit wr,
                         input logic [23:0] a, input logic [15:0] wd,
                         input logic [15:0] rin, input bit poke);
    string mode_req;
    mode_req = dm ? (b16 ? "R7" : "R8") : (b16 ? "R5" : "R6");
    @(negedge clk);
    cfg_bus16 = b16; cfg_demux = dm;
    req_write = wr; req_addr = a; req_wdata = wd; ad_in = rin;
    req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= T; k++) begin
      bit in_cyc, addr_win, is_data, drv_hi, drv_lo;
      logic [7:0] v_hi, v_lo;
      logic [15:0] exp_out;
      string pin_req;
      @(negedge clk);
      if (k == 0) begin
        req_valid = poke;
        if (poke) begin
          req_addr = ~a;
          req_write = ~wr;
        end
      end
      in_cyc   = (k < T);
      addr_win = (k < A + S);
      is_data  = in_cyc && !addr_win;
      drv_hi = in_cyc && (b16 ? (wr || (!dm && addr_win)) : 1'b1);
      drv_lo = in_cyc && (wr || (!dm && addr_win));
      v_hi = (!dm && (!b16 || addr_win)) ? a[15:8] : wd[15:8];
      v_lo = (!dm && addr_win) ? a[7:0] : wd[7:0];
      exp_out = {drv_hi ? v_hi : 8'h00, drv_lo ? v_lo : 8'h00};
      pin_req = (!wr && is_data) ? "R9" : (in_cyc ? mode_req : "R12");
      chk(pin_req, "pins {oe_hi,oe_lo,ad}",
          {14'd0, ad_oe_hi, ad_oe_lo, ad_out},
          {14'd0, drv_hi, drv_lo, exp_out});
      chk("R3", "ale", {31'd0, ale}, {31'd0, (k < A)});
      chk("R4", "ready", {31'd0, req_ready}, {31'd0, (k == T)});
      chk(poke ? "R11" : "R2", "ext_addr", {12'd0, ext_addr},
          {12'd0, a[19:0]});
      if (k == T) begin
        if (!wr) last_rd = b16 ? rin : {8'h00, rin[7:0]};
        chk("R10", "rsp_rdata", {16'd0, rsp_rdata}, {16'd0, last_rd});
        req_valid = 1'b0;
      end
    end
    idle_check(a[19:0], poke ? "R11" : "R2");
    idle_check(a[19:0], poke ? "R11" : "R2");
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs",
        {12'd0, ale, ad_oe_hi, ad_oe_lo, req_ready, ad_out}, 32'd0);
    chk("R1", "reset addr/rdata", {12'd0, ext_addr}, 32'd0);
    chk("R1", "reset rdata", {16'd0, rsp_rdata}, 32'd0);
    rst_n = 1'b1;
    idle_check(20'd0, "R2");
    for (int p = 0; p < 3; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        for (int w = 0; w < 2; w++) begin
          logic [23:0] a;
          logic [15:0] wd, rin;
          a   = 24'hF00000 ^ (24'h13A5C7 * (p + 1)) ^ (24'h1111 * cfg);
          wd  = 16'hA55A ^ (16'h1357 * (p + 3)) ^ 16'(w * 16'h0F0F);
          rin = 16'h6C93 ^ (16'h2468 * (p + cfg + 1));
          run_txn(cfg[0], cfg[1], w[0], a, wd, rin, (p == 2));
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule